// File: doc/BRIEF.md
# Trap and Exception-Return Sequencer

This block sits beside instruction fetch in a 32-bit load/store core and resolves the three special instructions that bypass ordinary sequencing: a software trap, a return from exception and the no-operation instruction. Each cycle it receives the fetched instruction word, the current program counter and a valid strobe. It returns the next program counter and a redirect flag. It also owns the interrupt address register (IAR) that holds the trap return address, and it exposes that register for observation.

A trap sends control to an absolute target. That target is the low 26-bit field of the instruction, padded with zeros. The trap also records the current PC plus 8 in the IAR. A return from exception sends control back to the address held in the IAR. A no-operation instruction, an unrecognised word, or a cycle with no valid instruction advances sequentially and leaves the IAR as it was. The outputs are combinational in the current inputs and the IAR. The IAR is written on the rising clock edge.

Top module: `exc_xfer_seq`

## Requirements
- R1: The opcode is bits [31:26] of the instruction word. The trap opcode is the parameter TRAP_OPC, default 6'h11. The return opcode is RFE_OPC, default 6'h10. The no-operation instruction has opcode NOP_OPC (default 6'h00) and function field bits [5:0] equal to NOP_FUNC (default 6'h00). At most one of the three decodes is active at a time.
- R2: For a valid trap, `redirect` is 1 in the same cycle and `nextPc` equals instruction bits [25:0] with zeros in bits [31:26].
- R3: At the clock edge that ends a valid trap cycle, the IAR takes the value curPc + 8.
- R4: For a valid return, `redirect` is 1 and `nextPc` equals the IAR value held in that cycle. The IAR itself does not change.
- R5: A valid no-operation instruction gives `redirect` = 0 and `nextPc` = curPc + 4, and it leaves the IAR unchanged.
- R6: If `instrValid` is 0, or the opcode is neither a trap nor a return, then `redirect` = 0 and `nextPc` = curPc + 4, and the IAR keeps its value. This holds even when the word carries a trap opcode.
- R7: Reset, which is asynchronous and active low, clears the IAR to 0. A return issued before any trap therefore redirects to address 0.
- R8: When two traps come in consecutive cycles, the second overwrites the IAR with its own curPc + 8. A return issued right after a trap uses the new value.
- R9: The PC + 4 and PC + 8 sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Fetched instruction |
| curPc | input | 32 | Address of the fetched instruction |
| nextPc | output | 32 | Address to fetch next |
| redirect | output | 1 | High for a non-sequential transfer |
| iarOut | output | 32 | Interrupt address register contents |

## Verification
A wrong IAR value does not appear on `nextPc` at the moment it is written. It shows first on `iarOut` one edge after the trap, and it reaches the control flow only when a later return redirects to the corrupted address. For that reason the scoreboard compares `iarOut` on every instruction, not only on returns. A decode fault shows within the same cycle as a wrong `redirect` or a wrong `nextPc`, and this applies to invalid or no-operation words that carry trap-like bits as well. The instruction streams include a return straight after reset, back-to-back traps, and a trap at the top of the address space, which exercises the wrap.

// File: rtl/exc_xfer_pkg.sv
package exc_xfer_pkg;
  // Strobes from decode control to the PC/IAR datapath
  typedef struct packed {
    logic takeTrap;
    logic takeRfe;
    logic saveIar;
  } xferStrobe_t;
endpackage

// File: rtl/exc_xfer_ctrl.sv
module exc_xfer_ctrl
  import exc_xfer_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int FUNC_W = 6,
  parameter logic [OPC_W-1:0] TRAP_OPC = 6'h11,
  parameter logic [OPC_W-1:0] RFE_OPC = 6'h10,
  parameter logic [OPC_W-1:0] NOP_OPC = 6'h00,
  parameter logic [FUNC_W-1:0] NOP_FUNC = 6'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [OPC_W-1:0]  opcodeFld,
  input  logic [FUNC_W-1:0] funcFld,
  output xferStrobe_t       strobe
);
  logic isTrap, isRfe, isNop;

  always_comb begin
    isTrap = instrValid && (opcodeFld == TRAP_OPC);
    isRfe  = instrValid && (opcodeFld == RFE_OPC);
    isNop  = instrValid && (opcodeFld == NOP_OPC) && (funcFld == NOP_FUNC);
    strobe.takeTrap = isTrap;
    strobe.takeRfe  = isRfe;
    strobe.saveIar  = isTrap;
  end

  AST_DECODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({isTrap, isRfe, isNop})); // R1

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    isNop |-> !strobe.takeTrap && !strobe.takeRfe && !strobe.saveIar); // R5
endmodule

// File: rtl/exc_xfer_dpath.sv
module exc_xfer_dpath
  import exc_xfer_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int NAME_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic [PC_W-1:0]   curPc,
  input  logic [NAME_W-1:0] nameFld,
  output logic [PC_W-1:0]   nextPc,
  output logic              redirect,
  output logic [PC_W-1:0]   iar
);
  localparam int PAD_W = PC_W - NAME_W;
  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);
  localparam logic [PC_W-1:0] RET_STEP = PC_W'(8);

  logic [PC_W-1:0] pcPlus4, pcPlus8, trapTarget;

  assign pcPlus4    = curPc + SEQ_STEP;
  assign pcPlus8    = curPc + RET_STEP;
  assign trapTarget = {{PAD_W{1'b0}}, nameFld};

  always_comb begin
    nextPc   = pcPlus4;
    redirect = 1'b0;
    if (strobe.takeTrap) begin
      nextPc   = trapTarget;
      redirect = 1'b1;
    end else if (strobe.takeRfe) begin
      nextPc   = iar;
      redirect = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) iar <= '0;
    else if (strobe.saveIar) iar <= pcPlus8;
  end

  AST_IAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.saveIar |=> $stable(iar)); // R6

  AST_RFE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRfe |-> redirect && (nextPc == iar)); // R4
endmodule

// File: rtl/exc_xfer_seq.sv
module exc_xfer_seq
  import exc_xfer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OPC_W = 6,
  parameter int FUNC_W = 6,
  parameter logic [OPC_W-1:0] TRAP_OPC = 6'h11,
  parameter logic [OPC_W-1:0] RFE_OPC = 6'h10,
  parameter logic [OPC_W-1:0] NOP_OPC = 6'h00,
  parameter logic [FUNC_W-1:0] NOP_FUNC = 6'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [WORD_W-1:0] curPc,
  output logic [WORD_W-1:0] nextPc,
  output logic              redirect,
  output logic [WORD_W-1:0] iarOut
);
  localparam int NAME_W = WORD_W - OPC_W;

  xferStrobe_t strobe;

  exc_xfer_ctrl #(
    .OPC_W(OPC_W), .FUNC_W(FUNC_W),
    .TRAP_OPC(TRAP_OPC), .RFE_OPC(RFE_OPC),
    .NOP_OPC(NOP_OPC), .NOP_FUNC(NOP_FUNC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .opcodeFld(instrWord[WORD_W-1 -: OPC_W]),
    .funcFld(instrWord[FUNC_W-1:0]),
    .strobe(strobe)
  );

  exc_xfer_dpath #(.PC_W(WORD_W), .NAME_W(NAME_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPc(curPc),
    .nameFld(instrWord[NAME_W-1:0]),
    .nextPc(nextPc), .redirect(redirect), .iar(iarOut)
  );

  AST_TRAP_SAVES_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && (instrWord[WORD_W-1 -: OPC_W] == TRAP_OPC)
      |=> iarOut == $past(curPc) + WORD_W'(8)); // R3

  AST_REDIRECT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> instrValid); // R6
endmodule

// File: tb/test_exc_xfer_seq.sv
module test_exc_xfer_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] curPc = '0;
  logic [31:0] nextPc, iarOut;
  logic        redirect;

  int checks = 0;
  int errors = 0;
  logic [31:0] modelIar = '0;

  typedef struct {
    logic [31:0] expNext;
    logic        expRedir;
    logic [31:0] expIar;
    string       req;
  } expItem_t;
  expItem_t sbQ[$];

  always #2.5 clk = ~clk;

  exc_xfer_seq i_exc_xfer_seq (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .curPc(curPc), .nextPc(nextPc), .redirect(redirect), .iarOut(iarOut)
  );

  function automatic logic [31:0] mkJ(input logic [5:0] opc, input logic [25:0] nm);
    return {opc, nm};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: present one instruction, predict results, push to scoreboard
  task automatic issue(input logic v, input logic [31:0] w,
                       input logic [31:0] pc, input string req);
    expItem_t it;
    @(posedge clk);
    #1;
    instrValid = v; instrWord = w; curPc = pc;
    it.req = req;
    it.expIar = modelIar;
    it.expNext = pc + 32'd4;
    it.expRedir = 1'b0;
    if (v && w[31:26] == 6'h11) begin
      it.expNext = {6'b0, w[25:0]};
      it.expRedir = 1'b1;
      modelIar = pc + 32'd8;
    end else if (v && w[31:26] == 6'h10) begin
      it.expNext = modelIar;
      it.expRedir = 1'b1;
    end
    sbQ.push_back(it);
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      check(it.req, "nextPc", nextPc, it.expNext);
      check(it.req, "redirect", {31'b0, redirect}, {31'b0, it.expRedir});
      check(it.req, "iarOut", iarOut, it.expIar);
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        check("R7", "iar in reset", iarOut, 32'h0);
        rstN = 1'b1;
        // R7: return before any trap goes to zero
        issue(1'b1, mkJ(6'h10, 26'h0), 32'h0000_0100, "R7");
        // R2/R3: trap
        issue(1'b1, mkJ(6'h11, 26'h3ff_fffc), 32'h0000_0200, "R2");
        issue(1'b1, 32'h0, 32'h03ff_fffc, "R3"); // NOP observes IAR=0x208, R5
        // R4: return to saved address
        issue(1'b1, mkJ(6'h10, 26'h155), 32'h0000_1000, "R4");
        // R6: invalid trap changes nothing
        issue(1'b0, mkJ(6'h11, 26'h123), 32'h0000_2000, "R6");
        issue(1'b1, 32'h8c41_0004, 32'h0000_2004, "R6");
        // R5: NOP with stray register bits but function 0
        issue(1'b1, 32'h0022_1800, 32'h0000_2008, "R5");
        // R1: opcode 0 with nonzero function is neither NOP nor transfer
        issue(1'b1, 32'h0000_0020, 32'h0000_200c, "R1");
        // R8: back-to-back traps then return
        issue(1'b1, mkJ(6'h11, 26'h000_0040), 32'h0000_3000, "R8");
        issue(1'b1, mkJ(6'h11, 26'h000_0080), 32'h0000_0040, "R8");
        issue(1'b1, mkJ(6'h10, 26'h0), 32'h0000_0080, "R8");
        // R9: wrap at top of address space
        issue(1'b1, mkJ(6'h11, 26'h000_0010), 32'hffff_fffc, "R9");
        issue(1'b1, mkJ(6'h10, 26'h0), 32'hffff_fffc, "R9");
        issue(1'b0, 32'h0, 32'hffff_fff8, "R9");
        issue(1'b0, 32'h0, 32'h0000_0000, "R6");
        repeat (3) @(negedge clk);
        check("R6", "scoreboard drained", 32'(sbQ.size()), 32'h0);
      end
      begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule